// File: doc/BRIEF.md
# Infrared Receive Buffer and Interrupt Register Block

This block sits between an infrared pulse encoder and a processor bus. The encoder hands it run-length bytes, and the block stores them in a receive queue of parameterised depth (16 or 64 entries). Software reads the queue one byte at a time through a single bus address. Each such read removes the oldest byte.

The same register space holds the encoder's controls: global and receive enables, a two-bit operating mode, an input inversion flag, and the noise and idle thresholds. The block drives these as plain outputs. Three sticky status flags record queue overflow, end of packet, and the queue passing a programmable fill level. A single interrupt line is asserted whenever a flag is set and its enable bit is also set. The status word also carries the live fill count, so one read tells software how many bytes to drain.

Top module: `ir_rx_regs`

## Requirements
- R1: After reset every register reads zero, the queue is empty, all encoder controls are low and `irq` is low.
- R2: Offset 0x00 holds global enable in bit 0, receive enable in bit 1 and mode in bits 5:4. These drive `glb_en`, `rx_en` and `mode`. All other bits read zero.
- R3: Offset 0x10 holds the inversion flag in bit 2, driving `pol_inv`. Offset 0x34 holds the noise threshold in bits 7:2 and the idle threshold in bits 15:8, driving `noise_thr` and `idle_thr`.
- R4: A byte from the encoder is stored only when global enable and receive enable are both 1. Otherwise it leaves the fill count unchanged.
- R5: A read of offset 0x20 returns the oldest byte in bits 7:0 and removes it. A read of an empty queue returns 0 and leaves the count at 0.
- R6: A byte that arrives while the queue is full and no read happens in the same cycle is dropped. It also sets the overflow flag, status bit 0.
- R7: An end-of-packet pulse from the encoder, while both enables are 1, sets status bit 1.
- R8: Status bit 4 sets when the fill count is strictly greater than the trigger level held in offset 0x2C from bit 8 upward.
- R9: Status (offset 0x30) bits from 8 upward report the live fill count.
- R10: Writing a 1 to a status flag bit clears that flag. Writing a 0 leaves it unchanged. A set event in the same cycle wins over the clear. Writing 0xFF clears all three flags.
- R11: `irq` is high exactly when some status flag is set and its enable bit at offset 0x2C is also set. The enable bits are overflow in bit 0, packet end in bit 1 and data available in bit 4.
- R12: Offset 0x2C reads back its three enable bits and the trigger level. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| sym_valid | input | 1 | Encoder byte strobe |
| sym_data | input | 8 | Encoder run-length byte |
| pkt_end | input | 1 | Encoder end-of-packet pulse |
| glb_en | output | 1 | Global enable to encoder |
| rx_en | output | 1 | Receive enable to encoder |
| mode | output | 2 | Operating mode to encoder |
| pol_inv | output | 1 | Input inversion to encoder |
| noise_thr | output | 6 | Noise threshold to encoder |
| idle_thr | output | 8 | Idle threshold to encoder |
| irq | output | 1 | Interrupt request |

## Verification
A table of register writes and readbacks sets all-ones into every configuration register. This separates the implemented bits from the reserved ones. The queue is exercised with bytes offered while disabled, which must be ignored. It is also driven with a short burst that is drained in order, a read of the empty queue, and a fill to capacity followed by one extra byte; draining afterwards shows that the extra byte was lost and not the oldest one. The flag tests use writes of a single bit against one flag that is set, to show that writing 1 clears and writing 0 holds. They also step the fill count across the trigger level, to show that the comparison is strict. Interrupt masking is checked by setting each flag with its enable bit both off and on.

// File: rtl/ir_rx_regs.sv
module ir_rx_regs #(
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          sym_valid,
  input  logic [7:0]    sym_data,
  input  logic          pkt_end,
  output logic          glb_en,
  output logic          rx_en,
  output logic [1:0]    mode,
  output logic          pol_inv,
  output logic [5:0]    noise_thr,
  output logic [7:0]    idle_thr,
  output logic          irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_RXCF = AW'('h10);
  localparam logic [AW-1:0] A_DATA = AW'('h20);
  localparam logic [AW-1:0] A_IEN  = AW'('h2C);
  localparam logic [AW-1:0] A_STAT = AW'('h30);
  localparam logic [AW-1:0] A_SAMP = AW'('h34);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             ie_ovf, ie_pend, ie_avail;
  logic [CNT_W-1:0] lvl;
  logic             st_ovf, st_pend, st_avail;

  wire wr_acc   = bus_sel & bus_wr;
  wire rd_acc   = bus_sel & ~bus_wr;
  wire rd_fifo  = rd_acc & (bus_addr == A_DATA);
  wire empty    = (count == '0);
  wire full     = (count == CNT_W'(DEPTH));
  wire pop      = rd_fifo & ~empty;
  wire active   = glb_en & rx_en;
  wire push_req = sym_valid & active;
  wire push     = push_req & (~full | pop);
  wire ovf_evt  = push_req & ~push;
  wire pend_evt = pkt_end & active;
  wire avl_evt  = (count > lvl);
  wire st_wr    = wr_acc & (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0; rx_en <= 1'b0; mode <= 2'b0;
      pol_inv <= 1'b0; noise_thr <= '0; idle_thr <= '0;
      ie_ovf <= 1'b0; ie_pend <= 1'b0; ie_avail <= 1'b0; lvl <= '0;
    end else if (wr_acc) begin
      case (bus_addr)
        A_CTRL: begin
          glb_en <= bus_wdata[0];
          rx_en  <= bus_wdata[1];
          mode   <= bus_wdata[5:4];
        end
        A_RXCF: pol_inv <= bus_wdata[2];
        A_SAMP: begin
          noise_thr <= bus_wdata[7:2];
          idle_thr  <= bus_wdata[15:8];
        end
        A_IEN: begin
          ie_ovf   <= bus_wdata[0];
          ie_pend  <= bus_wdata[1];
          ie_avail <= bus_wdata[4];
          lvl      <= bus_wdata[8 +: CNT_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ovf <= 1'b0; st_pend <= 1'b0; st_avail <= 1'b0;
    end else begin
      st_ovf   <= (st_ovf   & ~(st_wr & bus_wdata[0])) | ovf_evt;
      st_pend  <= (st_pend  & ~(st_wr & bus_wdata[1])) | pend_evt;
      st_avail <= (st_avail & ~(st_wr & bus_wdata[4])) | avl_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= sym_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (bus_addr)
        A_CTRL: bus_rdata = {26'b0, mode, 2'b0, rx_en, glb_en};
        A_RXCF: bus_rdata = {29'b0, pol_inv, 2'b0};
        A_DATA: bus_rdata = empty ? 32'b0 : {24'b0, mem[rd_ptr]};
        A_IEN:  bus_rdata = {{(24-CNT_W){1'b0}}, lvl, 3'b0, ie_avail, 2'b0, ie_pend, ie_ovf};
        A_STAT: bus_rdata = {{(24-CNT_W){1'b0}}, count, 3'b0, st_avail, 2'b0, st_pend, st_ovf};
        A_SAMP: bus_rdata = {16'b0, idle_thr, noise_thr, 2'b0};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = (st_ovf & ie_ovf) | (st_pend & ie_pend) | (st_avail & ie_avail);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R6
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> count == $past(count)); // R6
  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> st_ovf); // R6
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fifo && empty && !push_req) |=> empty); // R5
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !rd_fifo) |=> count == $past(count)); // R4
  AST_W1C_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[1] && !pend_evt) |=> !st_pend); // R10
endmodule

// File: tb/ir_rx_regs_tb.sv
module ir_rx_regs_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam logic [31:0] LVL_MASK = ((32'd1 << CW) - 1) << 8;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        sym_valid = 0, pkt_end = 0;
  logic [7:0]  sym_data = 0;
  logic        glb_en, rx_en, pol_inv, irq;
  logic [1:0]  mode;
  logic [5:0]  noise_thr;
  logic [7:0]  idle_thr;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #(CLK_P/2) clk = ~clk;

  ir_rx_regs #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sym_valid(sym_valid), .sym_data(sym_data), .pkt_end(pkt_end),
    .glb_en(glb_en), .rx_en(rx_en), .mode(mode), .pol_inv(pol_inv),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .irq(irq));

  localparam int NV = 5;
  localparam logic [7:0]  T_ADDR [NV] = '{8'h00, 8'h10, 8'h34, 8'h2C, 8'h00};
  localparam logic [31:0] T_WR   [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0021};
  localparam logic [31:0] T_EXP  [NV] = '{32'h33, 32'h4, 32'hFFFC,
                                          32'h13 | LVL_MASK, 32'h21};
  localparam string       T_REQ  [NV] = '{"R2", "R3", "R3", "R12", "R2"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); sym_valid = 1; sym_data = b;
    @(negedge clk); sym_valid = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h30, rv); chk("R1 status", rv, 0);
    rd(8'h00, rv); chk("R1 ctrl", rv, 0);
    chk("R1 outputs", {glb_en, rx_en, mode, pol_inv, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(T_ADDR[i], T_WR[i]);
      rd(T_ADDR[i], rv); chk(T_REQ[i], rv, T_EXP[i]);
    end
    chk("R2 pins", {glb_en, rx_en, mode}, 4'b1_0_10);
    chk("R3 pins", {pol_inv, noise_thr, idle_thr}, {1'b1, 6'h3F, 8'hFF});

    wr(8'h2C, 32'h0);
    push(8'h55);
    rd(8'h30, rv); chk("R4 partial enable", rv, 0);
    wr(8'h00, 32'h0); push(8'h56);
    rd(8'h30, rv); chk("R4 disabled", rv, 0);
    wr(8'h00, 32'h3);

    push(8'hA1); push(8'hB2); push(8'hC3);
    rd(8'h30, rv); chk("R9 count 3", rv & 32'hFFFF_FF00, 32'h300);
    rd(8'h20, rv); chk("R5 first", rv, 32'hA1);
    rd(8'h30, rv); chk("R9 count 2", rv & 32'hFFFF_FF00, 32'h200);
    rd(8'h20, rv); chk("R5 second", rv, 32'hB2);
    rd(8'h20, rv); chk("R5 third", rv, 32'hC3);
    rd(8'h20, rv); chk("R5 empty read", rv, 0);
    rd(8'h30, rv); chk("R5 empty count", rv & 32'hFFFF_FF00, 0);
    wr(8'h30, 32'hFF);

    for (int i = 0; i < DEPTH; i++) push(8'(i));
    rd(8'h30, rv); chk("R6 no ovf at full", rv & 32'h1, 0);
    push(8'hEE);
    rd(8'h30, rv); chk("R6 ovf flag and count", rv & 32'hFFFF_FF01, (DEPTH << 8) | 1);
    chk("R11 masked", {31'b0, irq}, 0);
    wr(8'h2C, 32'h1);
    chk("R11 unmasked", {31'b0, irq}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h20, rv); chk("R6 order kept", rv, 32'(i));
    end
    wr(8'h30, 32'h2);
    rd(8'h30, rv); chk("R10 zero bit holds", rv & 32'h1, 1);
    wr(8'h30, 32'h1);
    rd(8'h30, rv); chk("R10 one clears", rv & 32'h1, 0);
    chk("R11 low", {31'b0, irq}, 0);

    @(negedge clk); pkt_end = 1; @(negedge clk); pkt_end = 0;
    rd(8'h30, rv); chk("R7 packet end", rv & 32'h2, 2);
    wr(8'h30, 32'hFF);
    rd(8'h30, rv); chk("R10 clear all", rv, 0);

    wr(8'h2C, 32'h210);
    push(8'h11); push(8'h22);
    rd(8'h30, rv); chk("R8 at level", rv & 32'h10, 0);
    chk("R11 avail off", {31'b0, irq}, 0);
    push(8'h33);
    rd(8'h30, rv); chk("R8 above level", rv & 32'h10, 32'h10);
    chk("R11 avail on", {31'b0, irq}, 1);
    for (int i = 0; i < 3; i++) rd(8'h20, rv);
    wr(8'h30, 32'h10);
    rd(8'h30, rv); chk("R10 avail cleared", rv, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule